// File: doc/BRIEF.md
# OTP Fuse Register Front End

This block is the register-side face of a one-time-programmable fuse macro. Software sees a 4 KiB window of 32-bit control registers on a simple request/ready bus. One of these registers is a read-only data port that returns the fuse word selected by the address register. The other registers drive macro pins in a real design: chip enable, strobe, trim, program, test mode and the rest. Here they are plain storage that reads back what was written. Only the address register is narrowed, to the 12 bits a fuse index needs.

The fuse contents are fixed at elaboration. Every word is all-ones except two. One word holds a serial-number parameter, and the next word up holds its bitwise complement, so software can check the serial number against its complement. The data port reads as 0x000000FF unless three enable bits are all set: bit 0 of chip-enable, bit 0 of strobe and bit 0 of trim. The bus has no path that writes the fuse array.

A two-state controller sequences each transfer. In ST_IDLE, a request is accepted and the controller moves to ST_RESP. In ST_RESP, ready is high for exactly one cycle with the read data and the error flag, and the controller always returns to ST_IDLE. A register write takes effect on the edge that accepts it.

Top module: `otpf_regif`

## Requirements
- R1: After reset, ready, err and rdata are 0. Every register reads 0. The data port reads 0x000000FF.
- R2: When req is high in ST_IDLE, the request is accepted. Ready is high in the next cycle only, and rdata and err are valid in that cycle. A req presented while ready is high is not accepted: it produces no response and no write. Write responses return rdata 0.
- R3: Byte offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38 each store and read back a full 32-bit value, independently of one another.
- R4: The address register at offset 0x00 keeps bits 11:0 of a write. Its bits 31:12 read as 0.
- R5: A read of the data port at offset 0x18 returns the fuse word indexed by the address register when bit 0 of chip-enable (0x0C), bit 0 of strobe (0x1C) and bit 0 of trim (0x34) are all 1.
- R6: If any of those three bits is 0, a read of the data port returns 0x000000FF.
- R7: Fuse word 0x0FC holds the SERIAL parameter and word 0x0FD holds ~SERIAL. Every other fuse word is 0xFFFFFFFF.
- R8: A write to offset 0x18 completes without error and changes no state.
- R9: Any word-aligned offset from 0x3C to 0xFFC sets err in the response. A read there returns 0, and a write there is dropped.
- R10: An access with addr[1:0] not equal to 0, or with a byte strobe other than 4'hF, sets err, returns 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the window |
| strb_i | input | 4 | Byte strobes; must be 4'hF |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Response valid (ST_RESP) |
| rdata_o | output | 32 | Read data, valid with ready |
| err_o | output | 1 | Error for bad offset or access width |

## Verification
The assertions assume that a requester issues a new request only when ready is low. They also assume that the address, direction and strobe inputs are stable in the accepting cycle, so that the sampled inputs describe the accepted transfer. The stimulus drives every request as a one-cycle pulse on the falling edge and waits until the response has been seen before it starts the next transfer. The single exception is a deliberate collision with the response cycle, and there the properties give no credit to the request that overlaps. The fallback property is tied to the internal enable product, so its relation to the data port is checked only for reads that complete without error.

// File: rtl/otpf_pkg.sv
package otpf_pkg;

    localparam int DATA_W   = 32;
    localparam int OFF_W    = 12;
    localparam int NUM_REGS = 15;
    localparam int REG_IW   = $clog2(NUM_REGS);
    localparam int WORD_W   = OFF_W - 2;

    // register slots by word index; decode and software depend on these
    localparam int RID_ADDR    = 0;
    localparam int RID_ADDR_IO = 1;
    localparam int RID_ADDR_SL = 2;
    localparam int RID_CHIP_EN = 3;
    localparam int RID_CLOCK   = 4;
    localparam int RID_DIN     = 5;
    localparam int RID_DOUT    = 6;
    localparam int RID_STROBE  = 7;
    localparam int RID_PROG    = 8;
    localparam int RID_TCTL    = 9;
    localparam int RID_TMODE   = 10;
    localparam int RID_TREP    = 11;
    localparam int RID_TREAD   = 12;
    localparam int RID_TRIM    = 13;
    localparam int RID_WEN     = 14;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic              fmt_ok;
        logic              mapped;
        logic [REG_IW-1:0] idx;
    } dec_t;

endpackage

// File: rtl/otpf_decode.sv
module otpf_decode
    import otpf_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  logic [3:0]       strb_i,
    output dec_t             dec_o
);
    logic [WORD_W-1:0] word;

    always_comb begin
        word          = off_i[OFF_W-1:2];
        dec_o.fmt_ok  = (off_i[1:0] == 2'b00) && (strb_i == 4'hF);
        dec_o.mapped  = (word < WORD_W'(NUM_REGS));
        dec_o.idx     = word[REG_IW-1:0];
    end
endmodule

// File: rtl/otpf_regbank.sv
module otpf_regbank
    import otpf_pkg::*;
#(
    parameter int ADDR_KEEP = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [REG_IW-1:0]                wr_idx_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    localparam int PAD_W = DATA_W - ADDR_KEEP;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == RID_DOUT) begin : g_port
            // data port: no storage behind it
            assign regs_o[g] = '0;
        end else if (g == RID_ADDR) begin : g_addr
            logic [ADDR_KEEP-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && (wr_idx_i == REG_IW'(g))) begin
                    q <= wdata_i[ADDR_KEEP-1:0];
                end
            end
            assign regs_o[g] = {{PAD_W{1'b0}}, q};
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && (wr_idx_i == REG_IW'(g))) begin
                    q <= wdata_i;
                end
            end
            assign regs_o[g] = q;
        end
    end
endmodule

// File: rtl/otpf_fuse_rom.sv
module otpf_fuse_rom
    import otpf_pkg::*;
#(
    parameter int          FUSE_DEPTH = 4096,
    parameter logic [31:0] SERIAL     = 32'h5A17_C3E9,
    parameter int          SERIAL_LOC = 'h0FC,
    localparam int         FUSE_AW    = $clog2(FUSE_DEPTH)
) (
    input  logic [FUSE_AW-1:0] idx_i,
    output logic [DATA_W-1:0]  word_o
);
    // contents are fixed, so the array is a comparator pair, not storage
    always_comb begin
        if (idx_i == FUSE_AW'(SERIAL_LOC)) begin
            word_o = SERIAL;
        end else if (idx_i == FUSE_AW'(SERIAL_LOC + 1)) begin
            word_o = ~SERIAL;
        end else begin
            word_o = '1;
        end
    end
endmodule

// File: rtl/otpf_bus_fsm.sv
module otpf_bus_fsm
    import otpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic              err_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic              accept_o,
    output logic              ready_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o
);
    bus_state_e        state_q, state_d;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (state_q == ST_IDLE) && req_i;
        ready_o  = (state_q == ST_RESP);
        err_o    = err_q;
        rdata_o  = rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else if (accept_o) begin
            err_q   <= err_i;
            rdata_q <= (we_i || err_i) ? '0 : rd_i;
        end else begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end
    end
endmodule

// File: rtl/otpf_regif.sv
module otpf_regif
    import otpf_pkg::*;
#(
    parameter int          FUSE_DEPTH = 4096,
    parameter logic [31:0] SERIAL     = 32'h5A17_C3E9,
    parameter int          SERIAL_LOC = 'h0FC,
    parameter int          ADDR_KEEP  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [11:0]       addr_i,
    input  logic [3:0]        strb_i,
    input  logic [31:0]       wdata_i,
    output logic              ready_o,
    output logic [31:0]       rdata_o,
    output logic              err_o
);
    localparam int FUSE_AW = $clog2(FUSE_DEPTH);
    localparam logic [DATA_W-1:0] FALLBACK = DATA_W'(8'hFF);

    dec_t                            dec;
    logic                            accept;
    logic                            bad;
    logic                            wr_en;
    logic                            dout_gate;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]               fuse_word;
    logic [DATA_W-1:0]               rd_val;

    otpf_decode u_dec (
        .off_i  (addr_i),
        .strb_i (strb_i),
        .dec_o  (dec)
    );

    assign bad   = !dec.fmt_ok || !dec.mapped;
    assign wr_en = accept && we_i && !bad && (dec.idx != REG_IW'(RID_DOUT));

    otpf_regbank #(.ADDR_KEEP(ADDR_KEEP)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (dec.idx),
        .wdata_i  (wdata_i),
        .regs_o   (regs)
    );

    otpf_fuse_rom #(
        .FUSE_DEPTH (FUSE_DEPTH),
        .SERIAL     (SERIAL),
        .SERIAL_LOC (SERIAL_LOC)
    ) u_rom (
        .idx_i  (regs[RID_ADDR][FUSE_AW-1:0]),
        .word_o (fuse_word)
    );

    assign dout_gate = regs[RID_CHIP_EN][0] & regs[RID_STROBE][0] & regs[RID_TRIM][0];

    always_comb begin
        if (dec.idx == REG_IW'(RID_DOUT)) begin
            rd_val = dout_gate ? fuse_word : FALLBACK;
        end else begin
            rd_val = regs[dec.idx];
        end
    end

    otpf_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .we_i     (we_i),
        .err_i    (bad),
        .rd_i     (rd_val),
        .accept_o (accept),
        .ready_o  (ready_o),
        .err_o    (err_o),
        .rdata_o  (rdata_o)
    );
endmodule

// File: rtl/otpf_regif_chk.sv
module otpf_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        we_i,
    input logic [11:0] addr_i,
    input logic        ready_o,
    input logic [31:0] rdata_o,
    input logic        err_o,
    input logic        gate_i
);
    // R2: an accepted request is answered on the next cycle
    p_accept_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ready_o) |=> ready_o);

    // R2: the response lasts one cycle
    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    // R10: error only appears inside a response
    p_err_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ready_o);

    // R9: an errored response carries zero data
    p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && err_o) |-> (rdata_o == 32'h0));

    // R6: a data-port read with the gate down returns the fallback
    p_dout_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !err_o && $past(req_i && !we_i && addr_i == 12'h018 && !gate_i))
        |-> (rdata_o == 32'h0000_00FF));

    // R4: the address register never reads back upper bits
    p_addr_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(req_i && !we_i && addr_i == 12'h000))
        |-> (rdata_o[31:12] == 20'h0));
endmodule

bind otpf_regif otpf_regif_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .ready_o (ready_o),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .gate_i  (dout_gate)
);

// File: tb/otpf_regif_bench.sv
module otpf_regif_bench;
    localparam logic [31:0] SER  = 32'h5A17_C3E9;
    localparam logic [31:0] NSER = ~SER;
    localparam int VW = 86;
    localparam int NV = 30;

    typedef struct packed {
        logic [3:0]  rq;
        logic        we;
        logic [11:0] off;
        logic [3:0]  strb;
        logic [31:0] wd;
        logic        xerr;
        logic [31:0] xrd;
    } vec_t;

    // {req tag, we, offset, strb, wdata, expected err, expected rdata}
    localparam logic [VW-1:0] VECS [NV] = '{
        {4'd6,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'h0000_00FF}, // R6 gate off
        {4'd1,  1'b0, 12'h00C, 4'hF, 32'h0,         1'b0, 32'h0},         // R1
        {4'd4,  1'b1, 12'h000, 4'hF, 32'hFFFF_F0FC, 1'b0, 32'h0},         // R4 write
        {4'd4,  1'b0, 12'h000, 4'hF, 32'h0,         1'b0, 32'h0000_00FC}, // R4 masked
        {4'd6,  1'b1, 12'h00C, 4'hF, 32'h1,         1'b0, 32'h0},
        {4'd6,  1'b1, 12'h01C, 4'hF, 32'h1,         1'b0, 32'h0},
        {4'd6,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'h0000_00FF}, // R6 trim off
        {4'd5,  1'b1, 12'h034, 4'hF, 32'h8000_0001, 1'b0, 32'h0},
        {4'd5,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, SER},           // R5 R7 serial
        {4'd7,  1'b1, 12'h000, 4'hF, 32'h0000_00FD, 1'b0, 32'h0},
        {4'd7,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, NSER},          // R7 complement
        {4'd7,  1'b1, 12'h000, 4'hF, 32'h0000_0123, 1'b0, 32'h0},
        {4'd7,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R7 blank word
        {4'd8,  1'b1, 12'h018, 4'hF, 32'hDEAD_BEEF, 1'b0, 32'h0},         // R8
        {4'd8,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF},
        {4'd8,  1'b0, 12'h000, 4'hF, 32'h0,         1'b0, 32'h0000_0123},
        {4'd3,  1'b1, 12'h004, 4'hF, 32'hCAFE_F00D, 1'b0, 32'h0},
        {4'd3,  1'b0, 12'h004, 4'hF, 32'h0,         1'b0, 32'hCAFE_F00D}, // R3
        {4'd3,  1'b1, 12'h038, 4'hF, 32'h1357_9BDF, 1'b0, 32'h0},
        {4'd3,  1'b0, 12'h038, 4'hF, 32'h0,         1'b0, 32'h1357_9BDF}, // R3
        {4'd9,  1'b1, 12'h03C, 4'hF, 32'hFFFF_FFFF, 1'b1, 32'h0},         // R9
        {4'd9,  1'b0, 12'h03C, 4'hF, 32'h0,         1'b1, 32'h0},
        {4'd9,  1'b0, 12'hFFC, 4'hF, 32'h0,         1'b1, 32'h0},
        {4'd10, 1'b1, 12'h00C, 4'h3, 32'h0,         1'b1, 32'h0},         // R10 strobe
        {4'd10, 1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R10 no write
        {4'd10, 1'b0, 12'h002, 4'hF, 32'h0,         1'b1, 32'h0},         // R10 misaligned
        {4'd6,  1'b1, 12'h00C, 4'hF, 32'h0,         1'b0, 32'h0},
        {4'd6,  1'b0, 12'h018, 4'hF, 32'h0,         1'b0, 32'h0000_00FF}, // R6 chip off
        {4'd6,  1'b1, 12'h00C, 4'hF, 32'h1,         1'b0, 32'h0},
        {4'd6,  1'b1, 12'h01C, 4'hF, 32'h0,         1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  strb = 4'hF;
    logic [31:0] wdata = '0;
    logic        ready;
    logic [31:0] rdata;
    logic        err;

    int nchk = 0;
    int nbad = 0;
    logic [31:0] got;
    logic        gerr;

    always #10 clk = ~clk;

    otpf_regif #(.SERIAL(SER)) u_otpf_regif (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .strb_i(strb), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .err_o(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [11:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; strb = s; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0; strb = 4'hF;
        check("R2 ready", {31'h0, ready}, 32'h1);
        rd = rdata;
        e  = err;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check("R1 ready", {31'h0, ready}, 32'h0);
        check("R1 err", {31'h0, err}, 32'h0);
        check("R1 rdata", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            xfer(v.we, v.off, v.strb, v.wd, got, gerr);
            if (got !== v.xrd || gerr !== v.xerr) begin
                nbad++;
                $display("FAIL R%0d vec %0d actual=%h/%b expected=%h/%b",
                         v.rq, i, got, gerr, v.xrd, v.xerr);
            end
            nchk++;
        end

        // R3: every plain register holds its own pattern
        for (int i = 1; i < 15; i++) begin
            if (i != 6) xfer(1'b1, 12'(i * 4), 4'hF, {8'(i), 8'hC3, ~8'(i), 8'h3C}, got, gerr);
        end
        for (int i = 1; i < 15; i++) begin
            if (i != 6) begin
                xfer(1'b0, 12'(i * 4), 4'hF, 32'h0, got, gerr);
                check("R3 readback", got, {8'(i), 8'hC3, ~8'(i), 8'h3C});
            end
        end

        // R2: a request overlapping the response cycle is not taken
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 12'h00C;
        @(negedge clk);
        check("R2 first resp", {31'h0, ready}, 32'h1);
        we = 1'b1; addr = 12'h008; wdata = 32'h7777_7777;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R2 overlap dropped", {31'h0, ready}, 32'h0);
        xfer(1'b0, 12'h008, 4'hF, 32'h0, got, gerr);
        check("R2 no overlap write", got, {8'd2, 8'hC3, ~8'd2, 8'h3C});
        xfer(1'b1, 12'h008, 4'hF, 32'h1234_5678, got, gerr);
        check("R2 write resp data", got, 32'h0);

        // R1: reset mid-run clears all state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        xfer(1'b0, 12'h034, 4'hF, 32'h0, got, gerr);
        check("R1 trim cleared", got, 32'h0);
        xfer(1'b0, 12'h018, 4'hF, 32'h0, got, gerr);
        check("R1 port fallback", got, 32'h0000_00FF);
        xfer(1'b0, 12'h000, 4'hF, 32'h0, got, gerr);
        check("R1 addr cleared", got, 32'h0);

        // R5: enable all three and read fuse word 0 (blank)
        xfer(1'b1, 12'h00C, 4'hF, 32'h1, got, gerr);
        xfer(1'b1, 12'h01C, 4'hF, 32'h1, got, gerr);
        xfer(1'b1, 12'h034, 4'hF, 32'h1, got, gerr);
        xfer(1'b0, 12'h018, 4'hF, 32'h0, got, gerr);
        check("R5 blank word", got, 32'hFFFF_FFFF);
        xfer(1'b1, 12'h000, 4'hF, 32'h0000_10FC, got, gerr);
        xfer(1'b0, 12'h018, 4'hF, 32'h0, got, gerr);
        check("R5 wrapped index serial", got, SER);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule